// File: doc/BRIEF.md
# PLL Clock Mode Sequencer

This block is the control half of a PLL-based clock generator. It runs on the oscillator clock and holds three settings: a multiplier ratio, a PLL shut-down bit and an undivided-clock bit. From these it drives the analog PLL (enable and multiplier) and the select lines of a glitch-free clock multiplexer (oscillator bypass, PLL output or PLL shut down). It also drives the post-divider enable that halves the core clock. The analog PLL and the multiplexer sit outside the block.

Every accepted ratio write holds the multiplexer on bypass while a counter in the oscillator domain times a fixed lock interval. A lock flag and a watchdog permit rise only when that interval ends. Software must follow an ordering discipline between the ratio, the undivided bit and the shut-down bit. The block refuses any write that breaks that discipline, leaves its settings untouched and raises a sticky error flag. All pins are plain control and status; there is no streamed data, so no valid/ready handshake applies.

Top module: `pll_mode_seq`

## Requirements
- R1: After reset the ratio is 0, clk_sel is bypass, pll_en and post_div_en are 1, locked, wdog_permit and both error flags are 0, and a lock interval starts from reset.
- R2: A ratio write with a value from 0 to MAX_RATIO that is not refused sets pll_mult to that value. A value above MAX_RATIO is ignored, leaves pll_mult unchanged and sets err_rsv.
- R3: An accepted ratio write clears locked on the next edge and restarts the lock interval, even if one is already running. locked rises exactly LOCK_CYCLES clock edges after the write edge, and wdog_permit equals locked.
- R4: clk_sel encoding is 2'b00 bypass, 2'b01 PLL, 2'b10 off. It is 2'b01 only when the ratio is non-zero, locked is 1 and the PLL is not shut down; otherwise it is bypass, unless R7 applies.
- R5: A ratio write in range is refused (no change, err_ord set) when the undivided bit is 1, when wdog_off is 0, or when the value is non-zero while the PLL is shut down.
- R6: A control write that would set the undivided bit from 0 to 1 while locked is 0 is refused entirely and sets err_ord. post_div_en is the inverse of the undivided bit.
- R7: A control write that would set the shut-down bit while the ratio is non-zero is refused entirely and sets err_ord. While the shut-down bit is 1, pll_en is 0 and clk_sel is 2'b10.
- R8: A control write in the same cycle as any ratio write strobe is refused entirely and sets err_ord. The ratio write is still judged on its own.
- R9: core_half gives the core clock in units of half the oscillator frequency: the ratio when clk_sel is PLL, else 1, multiplied by 2 when the undivided bit is 1.
- R10: err_rsv and err_ord, once set, stay 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, clocks all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_wr | input | 1 | Ratio register write strobe |
| ratio_wdata | input | RATIO_W | Ratio value to write |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_pll_off | input | 1 | New value of the PLL shut-down bit |
| ctl_undiv | input | 1 | New value of the undivided-clock bit |
| wdog_off | input | 1 | High while the system watchdog is disabled |
| clk_sel | output | 2 | Clock multiplexer select (R4 encoding) |
| pll_mult | output | RATIO_W | Multiplier ratio to the PLL |
| pll_en | output | 1 | PLL enable, low when shut down |
| post_div_en | output | 1 | Divide-by-two stage enable |
| locked | output | 1 | Lock interval complete |
| wdog_permit | output | 1 | Watchdog may be re-enabled |
| core_half | output | RATIO_W+1 | Core clock in half-oscillator units |
| err_rsv | output | 1 | Sticky: reserved ratio written |
| err_ord | output | 1 | Sticky: write refused by an ordering rule |

## Verification
The bench builds the block with LOCK_CYCLES set to 16 while keeping the 4-bit ratio and MAX_RATIO of 10. The short interval puts several complete lock intervals within reach of a short run: the lock from reset, restarts in the middle of an interval, and refusals that depend on whether locked is already high. Keeping the ratio width and limit at their defaults means the reserved codes 11 to 15 and the doubled core factor of 20 are exercised as they would be in use.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
  typedef enum logic [1:0] {
    SRC_BYPASS = 2'b00,
    SRC_PLL    = 2'b01,
    SRC_OFF    = 2'b10
  } clk_src_e;
endpackage

// File: rtl/pll_reg_guard.sv
// Holds the ratio, shut-down and undivided settings and applies the
// write ordering rules before any of them may change.
module pll_reg_guard #(
  parameter int RATIO_W   = 4,
  parameter int MAX_RATIO = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ratio_wr,
  input  logic [RATIO_W-1:0] ratio_wdata,
  input  logic               ctl_wr,
  input  logic               ctl_pll_off,
  input  logic               ctl_undiv,
  input  logic               wdog_off,
  input  logic               locked,
  output logic [RATIO_W-1:0] ratio_q,
  output logic               pll_off_q,
  output logic               undiv_q,
  output logic               ratio_accept,
  output logic               err_rsv,
  output logic               err_ord
);
  localparam logic [RATIO_W-1:0] RATIO_TOP = RATIO_W'(MAX_RATIO);

  logic rsv_hit;
  logic ratio_bad;
  logic undiv_rise;
  logic off_rise;
  logic ctl_bad;
  logic ctl_accept;

  always_comb begin
    rsv_hit      = ratio_wr && (ratio_wdata > RATIO_TOP);
    ratio_bad    = ratio_wr && !rsv_hit &&
                   (undiv_q || !wdog_off || (pll_off_q && (ratio_wdata != '0)));
    ratio_accept = ratio_wr && !rsv_hit && !ratio_bad;
    undiv_rise   = ctl_undiv && !undiv_q;
    off_rise     = ctl_pll_off && !pll_off_q;
    ctl_bad      = ctl_wr &&
                   (ratio_wr || (undiv_rise && !locked) || (off_rise && (ratio_q != '0)));
    ctl_accept   = ctl_wr && !ctl_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q   <= '0;
      pll_off_q <= 1'b0;
      undiv_q   <= 1'b0;
    end else begin
      if (ratio_accept) ratio_q <= ratio_wdata;
      if (ctl_accept) begin
        pll_off_q <= ctl_pll_off;
        undiv_q   <= ctl_undiv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_rsv <= 1'b0;
      err_ord <= 1'b0;
    end else begin
      if (rsv_hit) err_rsv <= 1'b1;
      if (ratio_bad || ctl_bad) err_ord <= 1'b1;
    end
  end
endmodule

// File: rtl/pll_lock_timer.sv
// Times the lock interval in oscillator cycles; restart wins over counting.
module pll_lock_timer #(
  parameter int LOCK_CYCLES = 131072
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic locked
);
  localparam int LOCK_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [LOCK_W-1:0] LAST = LOCK_W'(LOCK_CYCLES - 1);

  logic [LOCK_W-1:0] cnt;
  logic              busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy   <= 1'b1;
      locked <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      busy   <= 1'b1;
      locked <= 1'b0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy   <= 1'b0;
        locked <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_out_map.sv
// Maps the settings and lock state onto the PLL and multiplexer controls.
module pll_out_map
  import pll_mode_pkg::*;
#(
  parameter int RATIO_W = 4
) (
  input  logic [RATIO_W-1:0] ratio_q,
  input  logic               pll_off_q,
  input  logic               undiv_q,
  input  logic               locked,
  output logic [1:0]         clk_sel,
  output logic [RATIO_W-1:0] pll_mult,
  output logic               pll_en,
  output logic               post_div_en,
  output logic [RATIO_W:0]   core_half
);
  clk_src_e         src;
  logic [RATIO_W:0] base;

  always_comb begin
    if (pll_off_q)                         src = SRC_OFF;
    else if (locked && (ratio_q != '0))    src = SRC_PLL;
    else                                   src = SRC_BYPASS;
    base        = (src == SRC_PLL) ? {1'b0, ratio_q} : (RATIO_W+1)'(1);
    core_half   = undiv_q ? {base[RATIO_W-1:0], 1'b0} : base;
    clk_sel     = src;
    pll_mult    = ratio_q;
    pll_en      = !pll_off_q;
    post_div_en = !undiv_q;
  end
endmodule

// File: rtl/pll_mode_seq.sv
module pll_mode_seq #(
  parameter int RATIO_W     = 4,
  parameter int MAX_RATIO   = 10,
  parameter int LOCK_CYCLES = 131072
) (
  input  logic               osc_clk,
  input  logic               rst_n,
  input  logic               ratio_wr,
  input  logic [RATIO_W-1:0] ratio_wdata,
  input  logic               ctl_wr,
  input  logic               ctl_pll_off,
  input  logic               ctl_undiv,
  input  logic               wdog_off,
  output logic [1:0]         clk_sel,
  output logic [RATIO_W-1:0] pll_mult,
  output logic               pll_en,
  output logic               post_div_en,
  output logic               locked,
  output logic               wdog_permit,
  output logic [RATIO_W:0]   core_half,
  output logic               err_rsv,
  output logic               err_ord
);
  logic [RATIO_W-1:0] ratio_q;
  logic               pll_off_q;
  logic               undiv_q;
  logic               ratio_accept;

  pll_reg_guard #(.RATIO_W(RATIO_W), .MAX_RATIO(MAX_RATIO)) u_guard (
    .clk(osc_clk), .rst_n(rst_n),
    .ratio_wr(ratio_wr), .ratio_wdata(ratio_wdata),
    .ctl_wr(ctl_wr), .ctl_pll_off(ctl_pll_off), .ctl_undiv(ctl_undiv),
    .wdog_off(wdog_off), .locked(locked),
    .ratio_q(ratio_q), .pll_off_q(pll_off_q), .undiv_q(undiv_q),
    .ratio_accept(ratio_accept), .err_rsv(err_rsv), .err_ord(err_ord)
  );

  pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk(osc_clk), .rst_n(rst_n), .restart(ratio_accept), .locked(locked)
  );

  pll_out_map #(.RATIO_W(RATIO_W)) u_map (
    .ratio_q(ratio_q), .pll_off_q(pll_off_q), .undiv_q(undiv_q), .locked(locked),
    .clk_sel(clk_sel), .pll_mult(pll_mult), .pll_en(pll_en),
    .post_div_en(post_div_en), .core_half(core_half)
  );

  assign wdog_permit = locked;
endmodule

// File: rtl/pll_mode_seq_chk.sv
module pll_mode_seq_chk #(
  parameter int RATIO_W   = 4,
  parameter int MAX_RATIO = 10
) (
  input logic               osc_clk,
  input logic               rst_n,
  input logic               ratio_wr,
  input logic [RATIO_W-1:0] ratio_wdata,
  input logic               ctl_wr,
  input logic               ratio_accept,
  input logic [1:0]         clk_sel,
  input logic [RATIO_W-1:0] pll_mult,
  input logic               pll_en,
  input logic               post_div_en,
  input logic               locked,
  input logic               err_rsv,
  input logic               err_ord
);
  p_reserved_kept_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (ratio_wr && (ratio_wdata > RATIO_W'(MAX_RATIO))) |=> $stable(pll_mult));

  p_restart_unlocks_r3: assert property (@(posedge osc_clk) disable iff (!rst_n)
    ratio_accept |=> !locked);

  p_pll_needs_lock_r4: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (clk_sel == 2'b01) |-> (locked && (pll_mult != '0) && pll_en));

  p_undiv_after_lock_r6: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $fell(post_div_en) |-> $past(locked));

  p_off_needs_zero_r7: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $fell(pll_en) |-> (pll_mult == '0));

  p_off_selects_off_r7: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !pll_en |-> (clk_sel == 2'b10));

  p_same_cycle_ctl_r8: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (ctl_wr && ratio_wr && !pll_en) |=> !pll_en);

  p_errors_sticky_r10: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !($fell(err_rsv) || $fell(err_ord)));
endmodule

bind pll_mode_seq pll_mode_seq_chk #(.RATIO_W(RATIO_W), .MAX_RATIO(MAX_RATIO)) u_chk (
  .osc_clk(osc_clk), .rst_n(rst_n), .ratio_wr(ratio_wr), .ratio_wdata(ratio_wdata),
  .ctl_wr(ctl_wr), .ratio_accept(ratio_accept), .clk_sel(clk_sel),
  .pll_mult(pll_mult), .pll_en(pll_en), .post_div_en(post_div_en),
  .locked(locked), .err_rsv(err_rsv), .err_ord(err_ord)
);

// File: tb/pll_mode_seq_tb.sv
`timescale 1ns/1ps
module pll_mode_seq_tb;
  localparam int RW = 4;
  localparam int MAXR = 10;
  localparam int L = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ratio_wr = 1'b0;
  logic [RW-1:0] ratio_wdata = '0;
  logic ctl_wr = 1'b0, ctl_pll_off = 1'b0, ctl_undiv = 1'b0, wdog_off = 1'b0;
  logic [1:0] clk_sel;
  logic [RW-1:0] pll_mult;
  logic pll_en, post_div_en, locked, wdog_permit, err_rsv, err_ord;
  logic [RW:0] core_half;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pll_mode_seq #(.RATIO_W(RW), .MAX_RATIO(MAXR), .LOCK_CYCLES(L)) u_dut (
    .osc_clk(clk), .rst_n(rst_n), .ratio_wr(ratio_wr), .ratio_wdata(ratio_wdata),
    .ctl_wr(ctl_wr), .ctl_pll_off(ctl_pll_off), .ctl_undiv(ctl_undiv),
    .wdog_off(wdog_off), .clk_sel(clk_sel), .pll_mult(pll_mult), .pll_en(pll_en),
    .post_div_en(post_div_en), .locked(locked), .wdog_permit(wdog_permit),
    .core_half(core_half), .err_rsv(err_rsv), .err_ord(err_ord)
  );

  // Behavioural reference: lock is the cycle index reaching a target.
  int m_ratio, cyc, lock_at;
  bit m_off, m_undiv, m_lock, m_ers, m_eord;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ratio = 0; m_off = 0; m_undiv = 0; m_lock = 0;
      m_ers = 0; m_eord = 0; cyc = 0; lock_at = L;
    end else begin
      bit take;
      take = 0;
      cyc++;
      if (ratio_wr) begin
        if (int'(ratio_wdata) > MAXR) m_ers = 1;
        else if (m_undiv || !wdog_off || (m_off && ratio_wdata != 0)) m_eord = 1;
        else take = 1;
      end
      if (ctl_wr) begin
        if (ratio_wr || (ctl_undiv && !m_undiv && !m_lock) ||
            (ctl_pll_off && !m_off && m_ratio != 0)) m_eord = 1;
        else begin m_off = ctl_pll_off; m_undiv = ctl_undiv; end
      end
      if (take) begin m_ratio = int'(ratio_wdata); lock_at = cyc + L; end
      m_lock = (cyc >= lock_at);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic int exp_sel();
    if (m_off) return 2;
    if (m_ratio != 0 && m_lock) return 1;
    return 0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int es, ec;
      es = exp_sel();
      ec = ((es == 1) ? m_ratio : 1) * (m_undiv ? 2 : 1);
      chk(int'(pll_mult) == m_ratio, "R2 pll_mult", int'(pll_mult), m_ratio);
      chk(locked == m_lock, "R3 locked", int'(locked), int'(m_lock));
      chk(wdog_permit == m_lock, "R3 wdog_permit", int'(wdog_permit), int'(m_lock));
      chk(int'(clk_sel) == es, "R4 clk_sel", int'(clk_sel), es);
      chk(post_div_en == !m_undiv, "R6 post_div_en", int'(post_div_en), int'(!m_undiv));
      chk(pll_en == !m_off, "R7 pll_en", int'(pll_en), int'(!m_off));
      chk(int'(core_half) == ec, "R9 core_half", int'(core_half), ec);
      chk(err_rsv == m_ers, "R2 err_rsv", int'(err_rsv), int'(m_ers));
      chk(err_ord == m_eord, "R5 err_ord", int'(err_ord), int'(m_eord));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ratio(input int v, input bit wd);
    @(negedge clk);
    ratio_wr = 1; ratio_wdata = RW'(v); wdog_off = wd;
    @(negedge clk);
    ratio_wr = 0; wdog_off = 0;
  endtask

  task automatic wr_ctl(input bit off, input bit ud);
    @(negedge clk);
    ctl_wr = 1; ctl_pll_off = off; ctl_undiv = ud;
    @(negedge clk);
    ctl_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    @(negedge clk);
    // R1: state right after reset release
    chk(clk_sel == 2'b00, "R1 reset clk_sel", int'(clk_sel), 0);
    chk(pll_mult == 0, "R1 reset pll_mult", int'(pll_mult), 0);
    chk(locked == 0, "R1 reset locked", int'(locked), 0);
    chk(pll_en && post_div_en, "R1 reset enables", int'({pll_en, post_div_en}), 3);
    chk(!err_rsv && !err_ord, "R1 reset errors", int'({err_rsv, err_ord}), 0);
    // R6: undivided bit before lock is refused
    wr_ctl(0, 1);
    chk(post_div_en == 1, "R6 early undiv refused", int'(post_div_en), 1);
    // R5: ratio write without the watchdog disabled is refused
    wr_ratio(4, 0);
    chk(pll_mult == 0, "R5 no wdog_off", int'(pll_mult), 0);
    tick(L + 2);
    chk(locked == 1, "R1 lock from reset", int'(locked), 1);
    // R3/R4: ratio 5 then full lock interval
    wr_ratio(5, 1);
    chk(locked == 0 && clk_sel == 2'b00, "R3 bypass during lock", int'(clk_sel), 0);
    tick(L);
    chk(clk_sel == 2'b01, "R4 pll after lock", int'(clk_sel), 1);
    // R9: undivided doubles core
    wr_ctl(0, 1);
    chk(core_half == 10, "R9 undivided core", int'(core_half), 10);
    // R5: ratio write while undivided is refused
    wr_ratio(3, 1);
    chk(pll_mult == 5, "R5 undiv blocks ratio", int'(pll_mult), 5);
    wr_ctl(0, 0);
    // R2: reserved codes ignored
    wr_ratio(12, 1);
    chk(pll_mult == 5 && err_rsv, "R2 reserved ignored", int'(pll_mult), 5);
    wr_ratio(15, 1);
    wr_ratio(10, 1);
    tick(L + 1);
    wr_ctl(0, 1);
    chk(core_half == 20, "R9 max core", int'(core_half), 20);
    wr_ctl(0, 0);
    // R3: restart in the middle of an interval
    wr_ratio(7, 1);
    tick(5);
    wr_ratio(2, 1);
    tick(L - 3);
    chk(locked == 0, "R3 restart holds unlock", int'(locked), 0);
    tick(4);
    chk(locked == 1 && clk_sel == 2'b01, "R3 relock", int'(locked), 1);
    // R7: shut-down refused with non-zero ratio, allowed at zero
    wr_ctl(1, 0);
    chk(pll_en == 1, "R7 off refused", int'(pll_en), 1);
    wr_ratio(0, 1);
    wr_ctl(1, 0);
    chk(pll_en == 0 && clk_sel == 2'b10, "R7 off selected", int'(clk_sel), 2);
    wr_ratio(4, 1);
    chk(pll_mult == 0, "R5 nonzero while off", int'(pll_mult), 0);
    // R8: simultaneous strobes refuse the control write
    @(negedge clk);
    ratio_wr = 1; ratio_wdata = 0; wdog_off = 1;
    ctl_wr = 1; ctl_pll_off = 0; ctl_undiv = 0;
    @(negedge clk);
    ratio_wr = 0; ctl_wr = 0; wdog_off = 0;
    chk(pll_en == 0, "R8 ctl refused with ratio", int'(pll_en), 0);
    wr_ctl(0, 0);
    tick(L + 2);
    // R10: errors remain set
    chk(err_rsv && err_ord, "R10 sticky errors", int'({err_rsv, err_ord}), 3);
    // R1: a second reset restores the defaults
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk(!err_rsv && !err_ord && pll_en, "R1 reset again", int'({err_rsv, err_ord}), 0);
    rst_n = 1;
    tick(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule